// File: doc/BRIEF.md
# Controller Data Register Bank

This block holds the 32-slot data register space of a small 8-bit controller and carries out the single-register operations that act on it. A 7-bit register operand selects one slot. The slots are the indirect window, one unimplemented slot, the program-counter low byte, the flag register, a pointer register, two port latches and 25 general-purpose RAM bytes. Each cycle, one operation is presented together with the accumulator (W) value and an external ALU result. The block returns three things: the operand it read, the accumulator value to keep, and the flag register. Register writes and flag updates happen on the next rising clock edge.

Slot 0 is not storage. It is a window onto the slot whose number is held in the low five bits of the pointer register. The flag register combines writable bits with bits that always read as 1. Load, increment, swap and ALU-result operations each carry a destination bit. That bit sends the result either back to the register or to the accumulator.

Top module: `regbank_top`

## Requirements
- R1: Only operand bits 4..0 select the slot. Bits 6..5 have no effect on which slot is read or written.
- R2: A store operation (op code 4) writes the W input into the addressed slot on the next clock edge, whatever the destination bit is, and changes no flag. RAM slots 7..31 read back exactly the byte last written.
- R3: Operand 0 reads and writes the slot numbered by pointer bits 4..0. When the pointer selects slot 0 itself, the read returns 0 and writes are dropped.
- R4: Slot 1 always reads 0 and ignores writes.
- R5: The flag register (slot 3) resets to 0x18. Bit 4 and bit 3 always read 1. Bits 0, 1, 2, 5, 6 and 7 take written values. Bit 2 is the zero flag.
- R6: The pointer register (slot 4) resets to 0xE0. Bits 7..5 always read 1, and bits 4..0 are writable.
- R7: The port A latch (slot 5) resets to 0x70 and stores only bits 3..0; bits 6..4 read 1 and bit 7 reads 0. The port B latch (slot 6) resets to 0x00 and stores 8 bits. The PC low byte (slot 2) resets to 0xFF and stores 8 bits.
- R8: For load, increment, swap and ALU-result operations, destination bit 1 writes the result to the slot and leaves the W output equal to the W input. Destination bit 0 puts the result on the W output and leaves the slot unchanged. The no-op (code 0) and store leave the W output equal to the W input.
- R9: Load (op code 1) yields the operand and increment (op code 2) yields the operand plus 1 modulo 256. Both set the zero flag to (result == 0) on the next edge.
- R10: Swap (op code 3) exchanges the operand's two nibbles and leaves every flag unchanged.
- R11: The ALU-result operation (op code 5) takes the ALU input as its result and updates the zero flag from it.
- R12: When a flag-updating operation writes its result into the flag register itself, the new zero flag overrides written bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation: 0 none, 1 load, 2 increment, 3 swap, 4 store, 5 ALU result |
| addr_i | input | 7 | Register operand |
| dest_i | input | 1 | Destination bit: 1 register, 0 accumulator |
| w_i | input | 8 | Current accumulator value |
| alu_i | input | 8 | Result from the external ALU |
| rd_data_o | output | 8 | Operand read at the resolved slot |
| w_o | output | 8 | Accumulator value to keep |
| status_o | output | 8 | Flag register as read |

## Verification
A wrong stored byte, a dropped write or a bad pointer decode appears on rd_data_o the first time that slot is addressed again. The bench therefore re-reads every slot directly, through the window, and with the unused operand bits set. A wrong zero flag shows on status_o one cycle after the operation that set it. A wrong result or destination choice shows on w_o in the same cycle, before the clock edge. Fixed-one and fixed-zero bits are compared on every read, so a bit that can be stored when it should not be is caught right after the write that tries to set it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W = 8;
  localparam int SLOT_W = 5;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_INC   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_STORE = 3'd4,
    OP_ALU   = 3'd5
  } op_e;

  localparam logic [SLOT_W-1:0] SL_WIN  = 5'd0;
  localparam logic [SLOT_W-1:0] SL_NONE = 5'd1;
  localparam logic [SLOT_W-1:0] SL_PCL  = 5'd2;
  localparam logic [SLOT_W-1:0] SL_STAT = 5'd3;
  localparam logic [SLOT_W-1:0] SL_PTR  = 5'd4;
  localparam logic [SLOT_W-1:0] SL_PA   = 5'd5;
  localparam logic [SLOT_W-1:0] SL_PB   = 5'd6;
  localparam int RAM_LO = 7;
  localparam int Z_BIT  = 2;

  function automatic logic [DATA_W-1:0] f_inc(input logic [DATA_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] f_swap(input logic [DATA_W-1:0] v);
    return {v[DATA_W/2-1:0], v[DATA_W-1:DATA_W/2]};
  endfunction
endpackage

// File: rtl/rb_resolve.sv
module rb_resolve
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] ptr_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              indirect_o
);
  logic [SLOT_W-1:0] direct;
  assign direct     = addr_i[SLOT_W-1:0];
  assign indirect_o = (direct == SL_WIN);
  assign slot_o     = indirect_o ? ptr_i : direct;
endmodule

// File: rtl/rb_unit.sv
module rb_unit
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic              dest_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] alu_i,
  output logic [DATA_W-1:0] res_o,
  output logic              reg_we_o,
  output logic              z_we_o,
  output logic              z_val_o,
  output logic [DATA_W-1:0] w_o
);
  op_e op;
  logic to_w;
  assign op = op_e'(op_i);

  always_comb begin
    res_o    = operand_i;
    reg_we_o = 1'b0;
    z_we_o   = 1'b0;
    to_w     = 1'b0;
    unique case (op)
      OP_LOAD:  begin res_o = operand_i;        z_we_o = 1'b1; reg_we_o = dest_i; to_w = !dest_i; end
      OP_INC:   begin res_o = f_inc(operand_i); z_we_o = 1'b1; reg_we_o = dest_i; to_w = !dest_i; end
      OP_SWAP:  begin res_o = f_swap(operand_i);               reg_we_o = dest_i; to_w = !dest_i; end
      OP_ALU:   begin res_o = alu_i;            z_we_o = 1'b1; reg_we_o = dest_i; to_w = !dest_i; end
      OP_STORE: begin res_o = w_i;                              reg_we_o = 1'b1; end
      default:  ;
    endcase
  end

  assign z_val_o = (res_o == '0);
  assign w_o     = to_w ? res_o : w_i;

  p_store_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STORE || op_i == OP_SWAP) |-> !z_we_o);
  p_w_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i && op_i != OP_NONE) |-> (w_o == w_i));
endmodule

// File: rtl/rb_store.sv
module rb_store
  import regbank_pkg::*;
#(
  parameter int N_SLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              z_we_i,
  input  logic              z_val_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [DATA_W-1:0] status_o,
  output logic [SLOT_W-1:0] ptr_o
);
  localparam logic [DATA_W-1:0] STAT_FIX = 8'h18;
  localparam logic [DATA_W-1:0] PTR_FIX  = 8'hE0;
  localparam logic [DATA_W-1:0] PA_FIX   = 8'h70;

  logic [DATA_W-1:0] pcl_q, stat_q, pb_q;
  logic [SLOT_W-1:0] ptr_q;
  logic [3:0]        pa_q;
  logic [DATA_W-1:0] ram_q [N_SLOT];
  logic [DATA_W-1:0] stat_nx;

  always_comb begin
    stat_nx = (we_i && slot_i == SL_STAT) ? wdata_i : stat_q;
    if (z_we_i) stat_nx[Z_BIT] = z_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcl_q  <= '1;
      stat_q <= STAT_FIX;
      ptr_q  <= '0;
      pa_q   <= '0;
      pb_q   <= '0;
    end else begin
      stat_q <= stat_nx;
      if (we_i) begin
        case (slot_i)
          SL_PCL: pcl_q <= wdata_i;
          SL_PTR: ptr_q <= wdata_i[SLOT_W-1:0];
          SL_PA:  pa_q  <= wdata_i[3:0];
          SL_PB:  pb_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_ram
    if (g >= RAM_LO) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ram_q[g] <= '0;
        else if (we_i && slot_i == SLOT_W'(g)) ram_q[g] <= wdata_i;
      end
    end else begin : g_hole
      assign ram_q[g] = '0;
    end
  end

  assign status_o = stat_q | STAT_FIX;
  assign ptr_o    = ptr_q;

  always_comb begin
    case (slot_i)
      SL_WIN, SL_NONE: rd_o = '0;
      SL_PCL:  rd_o = pcl_q;
      SL_STAT: rd_o = status_o;
      SL_PTR:  rd_o = PTR_FIX | DATA_W'(ptr_q);
      SL_PA:   rd_o = PA_FIX | DATA_W'(pa_q);
      SL_PB:   rd_o = pb_q;
      default: rd_o = ram_q[slot_i];
    endcase
  end

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SL_NONE) |-> (rd_o == '0));
  p_self_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SL_WIN) |-> (rd_o == '0));
  p_fixed_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[4] && status_o[3]);
  p_ptr_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SL_PTR) |-> (rd_o[7:5] == 3'b111));
  p_port_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SL_PA) |-> (rd_o[7:4] == 4'b0111));
  p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    z_we_i |=> (status_o[Z_BIT] == $past(z_val_i)));
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!z_we_i && !(we_i && slot_i == SL_STAT)) |=> $stable(status_o));
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int N_SLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dest_i,
  input  logic [7:0]        w_i,
  input  logic [7:0]        alu_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        w_o,
  output logic [7:0]        status_o
);
  logic [SLOT_W-1:0] slot, ptr;
  logic              indirect, reg_we, z_we, z_val;
  logic [DATA_W-1:0] res;

  rb_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .addr_i(addr_i), .ptr_i(ptr), .slot_o(slot), .indirect_o(indirect)
  );

  rb_unit u_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dest_i(dest_i),
    .operand_i(rd_data_o), .w_i(w_i), .alu_i(alu_i),
    .res_o(res), .reg_we_o(reg_we), .z_we_o(z_we), .z_val_o(z_val), .w_o(w_o)
  );

  rb_store #(.N_SLOT(N_SLOT)) u_store (
    .clk(clk), .rst_n(rst_n), .slot_i(slot), .we_i(reg_we), .wdata_i(res),
    .z_we_i(z_we), .z_val_i(z_val), .rd_o(rd_data_o), .status_o(status_o),
    .ptr_o(ptr)
  );

  p_window_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    indirect |-> (slot == ptr));
  p_high_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !indirect |-> (slot == addr_i[SLOT_W-1:0]));
endmodule

// File: tb/regbank_top_bench.sv
module regbank_top_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [6:0] addr_i = '0;
  logic dest_i = 1'b0;
  logic [7:0] w_i = '0, alu_i = '0;
  logic [7:0] rd_data_o, w_o, status_o;
  int n_chk = 0, n_err = 0;
  logic [7:0] m [32];

  always #4 clk = ~clk;

  regbank_top u_regbank_top (.*);

  initial begin
    #150000;
    n_err++; n_chk++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [6:0] a);
    return (a[4:0] == 0) ? int'(m[4][4:0]) : int'(a[4:0]);
  endfunction

  function automatic logic [7:0] mread(input int s);
    return (s < 2) ? 8'h00 : m[s];
  endfunction

  function automatic void mwrite(input int s, input logic [7:0] v);
    case (s)
      0, 1: ;
      3: m[3] = v | 8'h18;
      4: m[4] = v | 8'hE0;
      5: m[5] = {4'b0111, v[3:0]};
      default: m[s] = v;
    endcase
  endfunction

  // op codes: 1 load, 2 inc, 3 swap, 4 store, 5 alu
  task automatic do_op(input string req, input logic [2:0] op, input logic [6:0] a,
                       input logic d, input logic [7:0] w, input logic [7:0] alu);
    int s;
    logic [7:0] opd, res, wexp;
    logic flag, toreg;
    @(negedge clk);
    op_i = op; addr_i = a; dest_i = d; w_i = w; alu_i = alu;
    s = eff(a);
    opd = mread(s);
    flag = (op == 1 || op == 2 || op == 5);
    case (op)
      2: res = opd + 8'd1;
      3: res = {opd[3:0], opd[7:4]};
      4: res = w;
      5: res = alu;
      default: res = opd;
    endcase
    toreg = (op == 4) || (op >= 1 && op <= 5 && d);
    wexp = (op >= 1 && op <= 5 && op != 4 && !d) ? res : w;
    #1;
    chk({req, " read"}, rd_data_o, opd);
    chk({req, " W"}, w_o, wexp);
    chk({req, " flags"}, status_o, m[3]);
    @(posedge clk);
    if (toreg) mwrite(s, res);
    if (flag) m[3][2] = (res == 0);
    #1 op_i = 3'd0;
  endtask

  task automatic peek(input string req, input logic [6:0] a);
    @(negedge clk);
    op_i = 3'd0; addr_i = a;
    #1 chk(req, rd_data_o, mread(eff(a)));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    m[2] = 8'hFF; m[3] = 8'h18; m[4] = 8'hE0; m[5] = 8'h70;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state R5 R6 R7
    for (int a = 1; a < 32; a++) peek("R7 reset", 7'(a));
    chk("R5 reset flags", status_o, 8'h18);
    // R2 R1: store all slots with upper operand bits varied
    for (int a = 1; a < 32; a++)
      do_op("R2 store", 3'd4, 7'(a) | 7'((a % 4) << 5), a[0], 8'(a * 37 + 5), 8'h00);
    for (int a = 1; a < 32; a++) peek("R1 readback", 7'(a) | 7'h60);
    // R4 unimplemented slot
    do_op("R4 write", 3'd4, 7'd1, 1'b1, 8'hA5, 8'h00);
    peek("R4 read", 7'd1);
    // R5 writable flag bits
    do_op("R5 flags", 3'd4, 7'd3, 1'b0, 8'hE7, 8'h00);
    peek("R5 readback", 7'd3);
    do_op("R5 clear", 3'd4, 7'd3, 1'b0, 8'h00, 8'h00);
    // R9 load, both destinations, zero and nonzero
    for (int a = 7; a < 32; a++) do_op("R9 load W", 3'd1, 7'(a), 1'b0, 8'h3C, 8'h00);
    do_op("R9 zero src", 3'd4, 7'd9, 1'b0, 8'h00, 8'h00);
    do_op("R9 load Z", 3'd1, 7'd9, 1'b1, 8'h11, 8'h00);
    // R9 increment including wrap
    do_op("R9 set FF", 3'd4, 7'd10, 1'b0, 8'hFF, 8'h00);
    do_op("R9 inc wrap", 3'd2, 7'd10, 1'b1, 8'h00, 8'h00);
    peek("R9 wrapped", 7'd10);
    for (int a = 7; a < 32; a++) do_op("R9 inc", 3'd2, 7'(a), a[1], 8'h5A, 8'h00);
    // R10 swap, both destinations, with Z set first
    do_op("R10 set Z", 3'd5, 7'd12, 1'b0, 8'h00, 8'h00);
    for (int a = 2; a < 32; a++) do_op("R10 swap", 3'd3, 7'(a), a[0], 8'h77, 8'h00);
    // R11 alu result path
    for (int v = 0; v < 256; v += 17) do_op("R11 alu", 3'd5, 7'd20, v[4], 8'h01, 8'(v));
    // R12 flag register as destination of flag op
    do_op("R12 alu->stat", 3'd5, 7'd3, 1'b1, 8'h00, 8'h00);
    do_op("R12 alu->stat nz", 3'd5, 7'd3, 1'b1, 8'h00, 8'h04);
    // R3 indirect through every pointer value
    for (int p = 0; p < 32; p++) begin
      do_op("R3 set ptr", 3'd4, 7'd4, 1'b0, 8'(p), 8'h00);
      do_op("R3 win store", 3'd4, 7'd0, 1'b0, 8'(p * 11 + 3), 8'h00);
      do_op("R3 win inc", 3'd2, 7'h20, 1'b1, 8'h00, 8'h00);
      peek("R3 win read", 7'd0);
    end
    // R8 no-op keeps W
    do_op("R8 nop", 3'd0, 7'd15, 1'b0, 8'h9C, 8'h00);
    for (int a = 0; a < 32; a++) peek("R2 final", 7'(a));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule